// File: doc/BRIEF.md
# Dual-Mechanism Configuration Port Decoder

This block sits inside a host bridge and turns accesses on a simple I/O bus into configuration requests for a downstream port. It offers the two legacy PC ways of reaching configuration space. The first is an address latch followed by a data window. The second is a pair of key bytes that opens a 4 KB I/O window, in which the address itself selects the device and register. A strap input picks the mechanism that is live. Registers that belong to the other mechanism are hidden: they read as zero and ignore writes.

Host accesses are single-cycle strobes on `io_rd` or `io_wr`. If both are high in the same cycle, the access is taken as a write. An access that only touches the block's own registers, or that misses, finishes with `io_done` on the next cycle. An access that maps to configuration space raises `cfg_req` and holds the bus, device, function, register, byte enables, direction and write data steady until `cfg_ack` arrives. `io_done` and the read data follow one cycle after the acknowledge. While a request is open, `io_busy` is high and host strobes are ignored.

Top module: `cfgport_decoder`

## Requirements
- R1: After reset, `cfg_req`, `io_done` and `io_busy` are low. The mechanism-1 address latch and both mechanism-2 bytes are zero, so reading dword 0x0CF8 returns 0 in either mode.
- R2: With `mech_sel`=0, a write to 0x0CF8 with all four byte enables set stores the whole 32-bit word. A read of 0x0CF8 returns that word unchanged.
- R3: With `mech_sel`=0, a write to 0x0CF8 whose byte enables are not all ones (byte or 16-bit access to 0x0CF8–0x0CFB) leaves the latch unchanged.
- R4: With `mech_sel`=0 and latch bit 31 set, an access to dword 0x0CFC raises one request. The request takes bus from latch bits 23:16, device from bits 15:11, function from bits 10:8 and register from bits 7:2. It also carries the host byte enables, the write data, and `cfg_write`=1 for writes.
- R5: With `mech_sel`=0 and latch bit 31 clear (for example after writing zero), a read of 0x0CFC returns 0xFFFFFFFF and a write is dropped. Neither raises a request.
- R6: With `mech_sel`=1, the key byte is byte lane 0 of dword 0x0CF8 and the bus-number byte is lane 2 (I/O 0x0CFA). Each lane is written when its byte enable is set. A read of 0x0CF8 returns {8'h00, bus byte, 8'h00, key byte}.
- R7: With `mech_sel`=1 and key bits 7:4 equal to 0xF, an access in 0xC000–0xCFFF raises a request. The device is address bits 11:8 (device bit 4 is 0), the register is address bits 7:2, the function is key bits 3:1, and the bus is the bus byte.
- R8: With `mech_sel`=1 and key bits 7:4 not 0xF (including key 0), reads in 0xC000–0xCFFF return 0xFFFFFFFF and writes are dropped. Neither raises a request.
- R9: Any other address, including the data path of the inactive mechanism, reads 0 and raises no request. A write to 0x0CF8 changes only the registers of the active mechanism.
- R10: A request stays high with all its fields stable until `cfg_ack`. `io_busy` is high meanwhile. `io_done` pulses on the cycle after the acknowledge, carrying `cfg_rdata` for a read and 0 for a write.
- R11: An access that raises no request completes with `io_done` on the cycle after its strobe.
- R12: A host strobe while `io_busy` is high, including in the cycle `cfg_ack` is sampled, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mech_sel | input | 1 | Strap: 0 selects the latch mechanism, 1 the key/window mechanism |
| io_addr | input | 16 | I/O byte address, dword aligned |
| io_be | input | 4 | Byte enables, lane 0 is bits 7:0 |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_done | output | 1 | Access completion pulse |
| io_busy | output | 1 | A configuration request is open |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_write | output | 1 | Request direction, 1 = write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Write data of the request |
| cfg_ack | input | 1 | Request acknowledge, one cycle |
| cfg_rdata | input | 32 | Read data, valid with cfg_ack |

## Verification
The acknowledge that closes an open request and a new host strobe can land in the same cycle. The bench turns off its automatic responder, opens a data-window read, and in the cycle it drives `cfg_ack` it also drives a full-dword write of a new address to 0x0CF8. The check passes only if `io_done` returns the acknowledged read data, `cfg_req` falls, no second request appears, and a later read of 0x0CF8 still shows the old latch value. A strobe issued earlier while the request is still waiting is judged in the same way.

// File: rtl/cfgport_decoder.sv
module cfgport_decoder #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter logic [3:0]  WIN_NIB   = 4'hC,
  parameter logic [3:0]  KEY_NIB   = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mech_sel,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_done,
  output logic        io_busy,
  output logic        cfg_req,
  output logic        cfg_write,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_reg,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic [31:0] cfg_rdata
);

  localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

  logic [31:0] m1_addr;
  logic [7:0]  m2_key;
  logic [7:0]  m2_bus;

  wire unused_lsb = ^io_addr[1:0];

  wire strobe   = io_rd | io_wr;
  wire accept   = strobe & ~cfg_req;
  wire hit_port = io_addr[15:2] == ADDR_PORT[15:2];
  wire hit_data = io_addr[15:2] == DATA_PORT[15:2];
  wire hit_win  = io_addr[15:12] == WIN_NIB;
  wire m1_on    = m1_addr[31];
  wire m2_on    = m2_key[7:4] == KEY_NIB;

  wire go_m1  = ~mech_sel & hit_data & m1_on;
  wire go_m2  = mech_sel & hit_win & m2_on;
  wire go_cfg = accept & (go_m1 | go_m2);

  logic [31:0] local_rd;
  always_comb begin
    local_rd = '0;
    if (hit_port)
      local_rd = mech_sel ? {8'h00, m2_bus, 8'h00, m2_key} : m1_addr;
    else if (~mech_sel & hit_data)
      local_rd = ALL_ONES;
    else if (mech_sel & hit_win)
      local_rd = ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_addr <= '0;
      m2_key  <= '0;
      m2_bus  <= '0;
    end else if (accept & io_wr & hit_port) begin
      if (~mech_sel & (io_be == 4'hF)) m1_addr <= io_wdata;
      if (mech_sel & io_be[0]) m2_key <= io_wdata[7:0];
      if (mech_sel & io_be[2]) m2_bus <= io_wdata[23:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_req   <= 1'b0;
      cfg_write <= 1'b0;
      cfg_bus   <= '0;
      cfg_dev   <= '0;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      io_done   <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_done <= 1'b0;
      if (cfg_req) begin
        if (cfg_ack) begin
          cfg_req  <= 1'b0;
          io_done  <= 1'b1;
          io_rdata <= cfg_write ? 32'h0 : cfg_rdata;
        end
      end else if (go_cfg) begin
        cfg_req   <= 1'b1;
        cfg_write <= io_wr;
        cfg_be    <= io_be;
        cfg_wdata <= io_wdata;
        if (mech_sel) begin
          cfg_bus  <= m2_bus;
          cfg_dev  <= {1'b0, io_addr[11:8]};
          cfg_func <= m2_key[3:1];
          cfg_reg  <= io_addr[7:2];
        end else begin
          cfg_bus  <= m1_addr[23:16];
          cfg_dev  <= m1_addr[15:11];
          cfg_func <= m1_addr[10:8];
          cfg_reg  <= m1_addr[7:2];
        end
      end else if (accept) begin
        io_done  <= 1'b1;
        io_rdata <= io_wr ? 32'h0 : local_rd;
      end
    end
  end

  assign io_busy = cfg_req;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req); // R10
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> $stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_func)
      && $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_write)); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> io_done && !cfg_req); // R10
  AST_M1_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !mech_sel && io_wr && hit_port && io_be != 4'hF |=> $stable(m1_addr)); // R3
  AST_M1_OFF_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req && !mech_sel && strobe && hit_data && !m1_addr[31] |=> !cfg_req && io_done); // R5
  AST_M2_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && mech_sel |-> cfg_dev[4] == 1'b0); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack && strobe |=> cfg_req && !io_done); // R12

endmodule

// File: tb/cfgport_decoder_tb.sv
module cfgport_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mech_sel = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_done, io_busy, cfg_req, cfg_write;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0;
  int errors = 0;

  bit          resp_en = 1'b1;
  int          ack_delay = 0;
  logic [31:0] rsp_data = '0;
  int          req_seen = 0;
  int          stab_err = 0;
  bit          in_req = 1'b0;
  int          hold = 0;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_func;
  logic [5:0]  cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;
  logic        cap_write;

  always #10 clk = ~clk;

  cfgport_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .mech_sel(mech_sel),
    .io_addr(io_addr), .io_be(io_be), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_done(io_done), .io_busy(io_busy),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_func(cfg_func), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  always @(negedge clk) begin
    if (resp_en && rst_n) begin
      if (cfg_ack) cfg_ack = 1'b0;
      else if (cfg_req) begin
        if (!in_req) begin
          in_req = 1'b1; req_seen++; hold = 0;
          cap_bus = cfg_bus; cap_dev = cfg_dev; cap_func = cfg_func; cap_reg = cfg_reg;
          cap_be = cfg_be; cap_wdata = cfg_wdata; cap_write = cfg_write;
        end else if (cap_bus !== cfg_bus || cap_dev !== cfg_dev || cap_func !== cfg_func ||
                     cap_reg !== cfg_reg || cap_be !== cfg_be || cap_wdata !== cfg_wdata ||
                     cap_write !== cfg_write)
          stab_err++;
        if (hold >= ack_delay) begin
          cfg_ack = 1'b1; cfg_rdata = rsp_data; in_req = 1'b0;
        end else hold++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_access(input logic [15:0] a, input logic [3:0] be, input bit wr,
                           input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    io_addr = a; io_be = be; io_wr = wr; io_rd = !wr; io_wdata = wd;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    waits = 0;
    while (!io_done && waits < 50) begin
      @(negedge clk);
      waits++;
    end
    rd = io_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int w;
    chk("R1 cfg_req", {31'b0, cfg_req}, 0);
    chk("R1 io_busy", {31'b0, io_busy}, 0);
    chk("R1 io_done", {31'b0, io_done}, 0);
    mech_sel = 1'b0;
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R1 latch", rd, 0);
    mech_sel = 1'b1;
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R1 key/bus", rd, 0);
    chk("R11 register latency", w, 0);
    mech_sel = 1'b0;
  endtask

  task automatic t_m1_latch();
    logic [31:0] rd; int w;
    io_access(16'h0CF8, 4'hF, 1, 32'h805A_9DAD, rd, w);
    chk("R11 write latency", w, 0);
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R2 readback", rd, 32'h805A_9DAD);
    chk("R2 masked", rd & 32'h80FF_FFFC, 32'h805A_9DAC);
  endtask

  task automatic t_m1_partial();
    logic [31:0] rd; int w;
    io_access(16'h0CF8, 4'b0001, 1, 32'h0, rd, w);
    io_access(16'h0CF8, 4'b1000, 1, 32'h0, rd, w);
    io_access(16'h0CF8, 4'b1100, 1, 32'h0, rd, w);
    io_access(16'h0CF8, 4'b0011, 1, 32'h1234_5678, rd, w);
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R3 partial writes ignored", rd, 32'h805A_9DAD);
  endtask

  task automatic t_m1_cfg();
    logic [31:0] rd; int w; int n;
    n = req_seen; ack_delay = 3; rsp_data = 32'hDEAD_BEEF;
    io_access(16'h0CFC, 4'hF, 0, 0, rd, w);
    chk("R4 one request", req_seen - n, 1);
    chk("R4 bus", {24'b0, cap_bus}, 32'h5A);
    chk("R4 dev", {27'b0, cap_dev}, 32'h13);
    chk("R4 func", {29'b0, cap_func}, 5);
    chk("R4 reg", {26'b0, cap_reg}, 32'h2B);
    chk("R4 dir read", {31'b0, cap_write}, 0);
    chk("R10 read data", rd, 32'hDEAD_BEEF);
    chk("R10 done one cycle after ack", w, 4);
    ack_delay = 0;
    io_access(16'h0CFC, 4'b0110, 1, 32'hCAFE_F00D, rd, w);
    chk("R4 dir write", {31'b0, cap_write}, 1);
    chk("R4 be", {28'b0, cap_be}, 32'h6);
    chk("R4 wdata", cap_wdata, 32'hCAFE_F00D);
    chk("R10 write done", w, 1);
    chk("R10 write rdata", rd, 0);
  endtask

  task automatic t_m1_off();
    logic [31:0] rd; int w; int n;
    io_access(16'h0CF8, 4'hF, 1, 32'h0, rd, w);
    n = req_seen;
    io_access(16'h0CFC, 4'hF, 0, 0, rd, w);
    chk("R5 disabled read", rd, 32'hFFFF_FFFF);
    io_access(16'h0CFC, 4'hF, 1, 32'h55, rd, w);
    chk("R5 no request", req_seen - n, 0);
    chk("R11 disabled latency", w, 0);
  endtask

  task automatic t_m2();
    logic [31:0] rd; int w; int n;
    mech_sel = 1'b1;
    io_access(16'h0CF8, 4'b0001, 1, 32'h0000_00F6, rd, w);
    io_access(16'h0CF8, 4'b0100, 1, 32'h003C_0000, rd, w);
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R6 key/bus readback", rd, 32'h003C_00F6);
    n = req_seen; ack_delay = 1; rsp_data = 32'h1357_9BDF;
    io_access(16'hC7A4, 4'hF, 0, 0, rd, w);
    chk("R7 one request", req_seen - n, 1);
    chk("R7 bus", {24'b0, cap_bus}, 32'h3C);
    chk("R7 dev", {27'b0, cap_dev}, 7);
    chk("R7 func", {29'b0, cap_func}, 3);
    chk("R7 reg", {26'b0, cap_reg}, 32'h29);
    chk("R7 data", rd, 32'h1357_9BDF);
    io_access(16'hCF00, 4'b1000, 1, 32'hAB00_0000, rd, w);
    chk("R7 dev 15", {27'b0, cap_dev}, 15);
    chk("R7 write be", {28'b0, cap_be}, 32'h8);
    ack_delay = 0;
  endtask

  task automatic t_m2_closed();
    logic [31:0] rd; int w; int n;
    n = req_seen;
    io_access(16'h0CF8, 4'b0001, 1, 32'h0, rd, w);
    io_access(16'hC100, 4'hF, 0, 0, rd, w);
    chk("R8 closed read", rd, 32'hFFFF_FFFF);
    io_access(16'h0CF8, 4'b0001, 1, 32'h76, rd, w);
    io_access(16'hC100, 4'hF, 0, 0, rd, w);
    chk("R8 no key read", rd, 32'hFFFF_FFFF);
    io_access(16'hC100, 4'hF, 1, 32'h1, rd, w);
    chk("R8 no request", req_seen - n, 0);
  endtask

  task automatic t_inactive();
    logic [31:0] rd; int w; int n;
    n = req_seen;
    mech_sel = 1'b1;
    io_access(16'h0CFC, 4'hF, 0, 0, rd, w);
    chk("R9 m2 mode data port", rd, 0);
    io_access(16'h0CF8, 4'hF, 1, 32'hFFFF_FFFF, rd, w);
    mech_sel = 1'b0;
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R9 latch untouched in m2", rd, 0);
    io_access(16'hC200, 4'hF, 0, 0, rd, w);
    chk("R9 m1 mode window", rd, 0);
    io_access(16'h0D00, 4'hF, 0, 0, rd, w);
    chk("R9 unclaimed", rd, 0);
    io_access(16'h0CF8, 4'hF, 1, 32'h8000_0000, rd, w);
    mech_sel = 1'b1;
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R9 key/bus untouched in m1", rd, 32'h00FF_00FF);
    chk("R9 no request", req_seen - n, 0);
    mech_sel = 1'b0;
  endtask

  task automatic t_busy();
    logic [31:0] rd; int w;
    io_access(16'h0CF8, 4'hF, 1, 32'h8001_0800, rd, w);
    resp_en = 1'b0;
    @(negedge clk);
    io_addr = 16'h0CFC; io_be = 4'hF; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk("R10 busy", {31'b0, io_busy}, 1);
    io_addr = 16'h0CF8; io_wr = 1'b1; io_wdata = 32'h8077_0000;
    @(negedge clk);
    io_wr = 1'b0;
    chk("R12 held while busy", {31'b0, cfg_req}, 1);
    chk("R12 no done while busy", {31'b0, io_done}, 0);
    cfg_ack = 1'b1; cfg_rdata = 32'h2468_ACE0;
    io_addr = 16'h0CF8; io_be = 4'hF; io_wr = 1'b1; io_wdata = 32'h80AA_5500;
    @(negedge clk);
    cfg_ack = 1'b0; io_wr = 1'b0;
    chk("R10 done after ack", {31'b0, io_done}, 1);
    chk("R10 ack data", io_rdata, 32'h2468_ACE0);
    chk("R10 req dropped", {31'b0, cfg_req}, 0);
    @(negedge clk);
    chk("R12 no new request", {31'b0, cfg_req}, 0);
    resp_en = 1'b1;
    io_access(16'h0CF8, 4'hF, 0, 0, rd, w);
    chk("R12 latch unchanged", rd, 32'h8001_0800);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_m1_latch();
    t_m1_partial();
    t_m1_cfg();
    t_m1_off();
    t_m2();
    t_m2_closed();
    t_inactive();
    t_busy();
    chk("R10 fields stable", stab_err, 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule